// File: doc/BRIEF.md
# Indexed Block Register Target for a Serial Management Bus

This block is the target side of a two-wire management bus (SMBus/I2C style) that configures a small clock fanout buffer. It oversamples the bus clock and data lines with the system clock and detects start, repeated start and stop conditions. It answers a 7-bit address taken from a three-level strap, and it serves an eight-byte register file through indexed block transfers only. Each write carries a starting index and a byte count. Each read first returns a count byte and then the register bytes.

A write is made of the address with the write bit, a starting index, a byte count and then that many data bytes, which land at consecutive indices. A read sets the index with a short write, issues a repeated start and sends the address with the read bit. The target then returns the stored readback count, followed by that many register bytes. The register fields drive the output enables, the amplitude code and the per-output edge-rate selects of the buffer.

Top module: `smbr_target`

## Requirements
- R1: After reset, out_en reads 5'h1F, amp_sel reads 2'b10, slew_fast reads 5'h1F, sda_drive_low is 0 and the readback count is 8.
- R2: The address is latched from strap_lvl on the first rising edge of pwr_good after reset: 2'b00 selects 7'h6B, 2'b01 selects 7'h6C, 2'b10 or 2'b11 selects 7'h6D. Before that edge no address is acknowledged. Later strap changes or pwr_good edges leave the address unchanged.
- R3: An address byte that does not match is not acknowledged, and the target does not drive SDA for the rest of that transfer.
- R4: A block write acknowledges the address, the index, the count and each of the count data bytes, and stores the data bytes at index, index+1 and so on. Any data byte past the count is not acknowledged and is not stored.
- R5: Only writable bits take write data. These are byte 0 bits 3:0, byte 1 bits 2:0, byte 2 bits 3:0, byte 3 bit 0 and byte 7 bits 4:0. Every other bit keeps its value, bytes 4 to 6 cannot be written, and a write at index 8 or higher is acknowledged and discarded.
- R6: After a repeated start with the read bit, the first byte sent is the readback count, zero-extended from byte 7 bits 4:0. The register bytes from the stored index follow.
- R7: Byte 4 reads 8'hFF, byte 5 reads {REV_ID, 4'b0001} and byte 6 reads {DEV_TYPE, 6'b000101}. Any index of 8 or more reads 8'hFF.
- R8: Once the counted register bytes have been sent, any further byte the host reads is 8'hFF.
- R9: A host NACK ends the read. The target releases SDA, and the next transfer is served normally.
- R10: out_en = {byte1[2], byte0[3:0]}, amp_sel = byte1[1:0] and slew_fast = {byte3[0], byte2[3:0]}.
- R11: A start or stop in the middle of a byte aborts the transfer, and the partly received byte is not stored.
- R12: While refclk_ok is low the target ignores the bus and never drives SDA.
- R13: sda_drive_low changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling system clock |
| rst_n | input | 1 | Synchronous active-low reset |
| refclk_ok | input | 1 | High while the reference clock runs; gates the bus engine |
| pwr_good | input | 1 | Power-good; its first rising edge latches the strap |
| strap_lvl | input | 2 | Three-level address strap: 00 low, 01 mid, 1x high |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_drive_low | output | 1 | Open-drain data drive; 1 pulls SDA low |
| out_en | output | 5 | Per-output enable fields |
| amp_sel | output | 2 | Output amplitude code (00 lowest .. 11 highest) |
| slew_fast | output | 5 | Per-output edge-rate select, 1 = fast |

## Verification
The hardest situations to reach from the pins are a start or stop that lands in the middle of a byte, and a read that runs past its stored count. The bench's bus host is built from single-bit tasks, so a test can issue a stop or a new start after any number of data bits and then read the target byte back to show that nothing was stored. For the overrun, the readback count is first lowered through a write to byte 7. The host then asks for one byte more than that count, and the scoreboard expects 8'hFF in that last position.

// File: rtl/smbr_pkg.sv
// Package: shared types and constants for the management-bus register target.
// Assumes an eight-byte register file and five buffer outputs.
package smbr_pkg;
    localparam int NREG = 8;
    localparam int NOUT = 5;

    typedef enum logic [2:0] {
        S_IDLE, S_RXBYTE, S_RXACK, S_TXBYTE, S_TXACK, S_WAIT
    } eng_state_t;

    typedef enum logic [1:0] {
        PH_ADDR, PH_INDEX, PH_COUNT, PH_DATA
    } rx_phase_t;

    // Maps the three strap levels to the target address.
    function automatic logic [6:0] strap_to_addr(input logic [1:0] lvl);
        case (lvl)
            2'b00:   return 7'h6B;
            2'b01:   return 7'h6C;
            default: return 7'h6D;
        endcase
    endfunction

    // Writable-bit mask per register byte.
    function automatic logic [7:0] wr_mask(input int unsigned i);
        case (i)
            0:       return 8'h0F;
            1:       return 8'h07;
            2:       return 8'h0F;
            3:       return 8'h01;
            7:       return 8'h1F;
            default: return 8'h00;
        endcase
    endfunction

    // Reset value per register byte.
    function automatic logic [7:0] rst_val(input int unsigned i);
        case (i)
            0:       return 8'h0F;
            1:       return 8'h06;
            2:       return 8'h0F;
            3:       return 8'h01;
            7:       return 8'h08;
            default: return 8'h00;
        endcase
    endfunction
endpackage

// File: rtl/smbr_sync.sv
// Module: synchronises SCL and SDA into the system clock and flags bus events.
// Assumes the system clock oversamples SCL by a wide margin; the lines idle high.
module smbr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_s,
    output logic start_det,
    output logic stop_det,
    output logic scl_rise,
    output logic scl_fall
);
    logic [STAGES-1:0] scl_ff;
    logic [STAGES-1:0] sda_ff;
    logic              scl_p;
    logic              sda_p;
    logic              scl_s;

    // Synchroniser chains plus one delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_ff <= '1;
            sda_ff <= '1;
            scl_p  <= 1'b1;
            sda_p  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[STAGES-2:0], scl_in};
            sda_ff <= {sda_ff[STAGES-2:0], sda_in};
            scl_p  <= scl_ff[STAGES-1];
            sda_p  <= sda_ff[STAGES-1];
        end
    end

    assign scl_s     = scl_ff[STAGES-1];
    assign sda_s     = sda_ff[STAGES-1];
    assign start_det = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
    assign scl_rise  = scl_s & ~scl_p;
    assign scl_fall  = ~scl_s & scl_p;
endmodule

// File: rtl/smbr_strap.sv
// Module: latches the target address from the strap on the first power-good rise.
// Assumes pwr_good is synchronous to clk; a reset re-arms the latch.
module smbr_strap (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwr_good,
    input  logic [1:0] strap_lvl,
    output logic [6:0] tgt_addr,
    output logic       addr_valid
);
    import smbr_pkg::*;

    logic pg_d;

    // One-shot capture of the strap level on the first power-good rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pg_d       <= 1'b0;
            addr_valid <= 1'b0;
            tgt_addr   <= '0;
        end else begin
            pg_d <= pwr_good;
            if (pwr_good && !pg_d && !addr_valid) begin
                tgt_addr   <= strap_to_addr(strap_lvl);
                addr_valid <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/smbr_regs.sv
// Module: eight-byte control register file with masked writes and a read mux.
// Assumes one write per cycle; the identity bytes are constants from parameters.
module smbr_regs #(
    parameter logic [3:0] REV_ID   = 4'h0,
    parameter logic [1:0] DEV_TYPE = 2'b11,
    parameter int         IDX_W    = 8,
    parameter int         CNT_W    = 5
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [IDX_W-1:0]           wr_idx,
    input  logic [7:0]                 wr_data,
    input  logic [IDX_W-1:0]           rd_idx,
    output logic [7:0]                 rd_data,
    output logic [CNT_W-1:0]           rd_count,
    output logic [smbr_pkg::NOUT-1:0]  out_en,
    output logic [1:0]                 amp_sel,
    output logic [smbr_pkg::NOUT-1:0]  slew_fast
);
    import smbr_pkg::*;

    localparam int RB = $clog2(NREG);

    logic [NREG-1:0][7:0] regs;

    // Masked byte writes; bits outside the mask keep their value.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NREG; i++) begin
            if (!rst_n) begin
                regs[i] <= rst_val(i);
            end else if (wr_en && wr_idx == IDX_W'(i)) begin
                regs[i] <= (regs[i] & ~wr_mask(i)) | (wr_data & wr_mask(i));
            end
        end
    end

    // Read mux: constant identity bytes and 8'hFF for reserved or out-of-range.
    always_comb begin
        if (rd_idx >= IDX_W'(NREG)) begin
            rd_data = 8'hFF;
        end else begin
            case (rd_idx[RB-1:0])
                3'd4:    rd_data = 8'hFF;
                3'd5:    rd_data = {REV_ID, 4'b0001};
                3'd6:    rd_data = {DEV_TYPE, 6'b000101};
                default: rd_data = regs[rd_idx[RB-1:0]];
            endcase
        end
    end

    assign rd_count  = regs[7][CNT_W-1:0];
    assign out_en    = {regs[1][2], regs[0][3:0]};
    assign amp_sel   = regs[1][1:0];
    assign slew_fast = {regs[3][0], regs[2][3:0]};
endmodule

// File: rtl/smbr_fsm.sv
// Module: bit-level bus engine for indexed block writes and counted block reads.
// Assumes clean event pulses from smbr_sync; SDA changes only after an SCL fall.
module smbr_fsm #(
    parameter int IDX_W = 8,
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             start_det,
    input  logic             stop_det,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             sda_s,
    input  logic [6:0]       tgt_addr,
    input  logic             addr_valid,
    input  logic [CNT_W-1:0] rd_count,
    input  logic [7:0]       rd_data,
    output logic [IDX_W-1:0] rd_idx,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic [7:0]       wr_data,
    output logic             sda_oe
);
    import smbr_pkg::*;

    eng_state_t       state;
    rx_phase_t        phase;
    logic [7:0]       sh;
    logic [3:0]       bitcnt;
    logic [IDX_W-1:0] idx;
    logic [7:0]       wr_left;
    logic [CNT_W-1:0] rd_left;
    logic             go_tx;
    logic             host_ack;
    logic             accept;
    logic [7:0]       nxt_byte;
    logic [7:0]       cnt_byte;

    // Decide whether the byte just received is acknowledged.
    always_comb begin
        case (phase)
            PH_ADDR: accept = addr_valid && (sh[7:1] == tgt_addr);
            PH_DATA: accept = (wr_left != 8'd0);
            default: accept = 1'b1;
        endcase
    end

    assign nxt_byte = (rd_left != '0) ? rd_data : 8'hFF;
    assign cnt_byte = {{(8-CNT_W){1'b0}}, rd_count};
    assign rd_idx   = idx;
    assign wr_idx   = idx;
    assign wr_data  = sh;
    assign wr_en    = active && !start_det && !stop_det && (state == S_RXBYTE)
                      && scl_fall && (bitcnt == 4'd8) && (phase == PH_DATA)
                      && (wr_left != 8'd0);

    // Engine sequencing: bus events first, then per-state bit handling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            phase    <= PH_ADDR;
            sh       <= '0;
            bitcnt   <= '0;
            idx      <= '0;
            wr_left  <= '0;
            rd_left  <= '0;
            go_tx    <= 1'b0;
            host_ack <= 1'b0;
            sda_oe   <= 1'b0;
        end else if (!active) begin
            state  <= S_IDLE;
            sda_oe <= 1'b0;
        end else if (start_det) begin
            state  <= S_RXBYTE;
            phase  <= PH_ADDR;
            bitcnt <= '0;
            go_tx  <= 1'b0;
            sda_oe <= 1'b0;
        end else if (stop_det) begin
            state  <= S_IDLE;
            sda_oe <= 1'b0;
        end else begin
            case (state)
                S_RXBYTE: begin
                    if (scl_rise && bitcnt < 4'd8) begin
                        sh     <= {sh[6:0], sda_s};
                        bitcnt <= bitcnt + 4'd1;
                    end else if (scl_fall && bitcnt == 4'd8) begin
                        if (accept) begin
                            sda_oe <= 1'b1;
                            state  <= S_RXACK;
                        end else begin
                            state <= S_WAIT;
                        end
                        case (phase)
                            PH_ADDR: begin
                                go_tx <= sh[0];
                                phase <= PH_INDEX;
                            end
                            PH_INDEX: begin
                                idx   <= sh;
                                phase <= PH_COUNT;
                            end
                            PH_COUNT: begin
                                wr_left <= sh;
                                phase   <= PH_DATA;
                            end
                            default: begin
                                if (wr_left != 8'd0) begin
                                    idx     <= idx + IDX_W'(1);
                                    wr_left <= wr_left - 8'd1;
                                end
                            end
                        endcase
                    end
                end
                S_RXACK: begin
                    if (scl_fall) begin
                        bitcnt <= '0;
                        if (go_tx) begin
                            sh      <= cnt_byte;
                            sda_oe  <= ~cnt_byte[7];
                            rd_left <= rd_count;
                            state   <= S_TXBYTE;
                        end else begin
                            sda_oe <= 1'b0;
                            state  <= S_RXBYTE;
                        end
                    end
                end
                S_TXBYTE: begin
                    if (scl_fall) begin
                        if (bitcnt == 4'd7) begin
                            sda_oe <= 1'b0;
                            state  <= S_TXACK;
                        end else begin
                            bitcnt <= bitcnt + 4'd1;
                            sh     <= {sh[6:0], 1'b0};
                            sda_oe <= ~sh[6];
                        end
                    end
                end
                S_TXACK: begin
                    if (scl_rise) begin
                        host_ack <= ~sda_s;
                    end else if (scl_fall) begin
                        if (host_ack) begin
                            sh     <= nxt_byte;
                            sda_oe <= ~nxt_byte[7];
                            bitcnt <= '0;
                            state  <= S_TXBYTE;
                            if (rd_left != '0) begin
                                idx     <= idx + IDX_W'(1);
                                rd_left <= rd_left - CNT_W'(1);
                            end
                        end else begin
                            state <= S_WAIT;
                        end
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/smbr_target.sv
// Module: top of the bus register target; wires synchroniser, strap latch,
// engine and register file. Assumes an external open-drain pad driven by
// sda_drive_low and a pull-up on the bus.
module smbr_target #(
    parameter logic [3:0] REV_ID      = 4'h0,
    parameter logic [1:0] DEV_TYPE    = 2'b11,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       refclk_ok,
    input  logic       pwr_good,
    input  logic [1:0] strap_lvl,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       sda_drive_low,
    output logic [4:0] out_en,
    output logic [1:0] amp_sel,
    output logic [4:0] slew_fast
);
    localparam int IDX_W = 8;
    localparam int CNT_W = 5;

    logic             sda_s, start_det, stop_det, scl_rise, scl_fall;
    logic [6:0]       tgt_addr;
    logic             addr_valid;
    logic [IDX_W-1:0] rd_idx, wr_idx;
    logic [7:0]       rd_data, wr_data;
    logic             wr_en;
    logic [CNT_W-1:0] rd_count;

    smbr_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .sda_s(sda_s), .start_det(start_det), .stop_det(stop_det),
        .scl_rise(scl_rise), .scl_fall(scl_fall)
    );

    smbr_strap u_strap (
        .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .strap_lvl(strap_lvl),
        .tgt_addr(tgt_addr), .addr_valid(addr_valid)
    );

    smbr_fsm #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .active(refclk_ok),
        .start_det(start_det), .stop_det(stop_det),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_s(sda_s),
        .tgt_addr(tgt_addr), .addr_valid(addr_valid),
        .rd_count(rd_count), .rd_data(rd_data), .rd_idx(rd_idx),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .sda_oe(sda_drive_low)
    );

    smbr_regs #(.REV_ID(REV_ID), .DEV_TYPE(DEV_TYPE), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data),
        .rd_count(rd_count), .out_en(out_en), .amp_sel(amp_sel),
        .slew_fast(slew_fast)
    );
endmodule

// File: rtl/smbr_target_chk.sv
// Module: property checker for smbr_target, attached with bind below.
// Assumes the bus host holds SCL low for several system clocks per bit.
module smbr_target_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       refclk_ok,
    input logic       scl_in,
    input logic       sda_drive_low,
    input logic [4:0] out_en,
    input logic [1:0] amp_sel,
    input logic [4:0] slew_fast,
    input logic [6:0] tgt_addr,
    input logic       addr_valid
);
    // R1: the cycle after a reset cycle shows the default fields.
    a_r1_reset_fields: assert property (@(posedge clk)
        !rst_n |=> (out_en == 5'h1F && amp_sel == 2'b10 && slew_fast == 5'h1F && !sda_drive_low));

    // R2: once latched, the address stays latched.
    a_r2_addr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid |=> addr_valid);

    // R2: the latched address value never moves.
    a_r2_addr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid |=> $stable(tgt_addr));

    // R12: no drive while the reference clock is absent.
    a_r12_quiet_no_ref: assert property (@(posedge clk) disable iff (!rst_n)
        !refclk_ok |=> !sda_drive_low);

    // R13: the data drive only toggles while SCL is low.
    a_r13_sda_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        (refclk_ok && $past(refclk_ok) && !$stable(sda_drive_low)) |-> !scl_in);
endmodule

bind smbr_target smbr_target_chk u_chk (
    .clk(clk), .rst_n(rst_n), .refclk_ok(refclk_ok), .scl_in(scl_in),
    .sda_drive_low(sda_drive_low), .out_en(out_en), .amp_sel(amp_sel),
    .slew_fast(slew_fast), .tgt_addr(tgt_addr), .addr_valid(addr_valid)
);

// File: tb/tb_smbr_target.sv
// Bench: bus host model driving scl/sda, scoreboard queue for read data.
module tb_smbr_target;
    localparam int Q = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       refclk_ok = 1'b1;
    logic       pwr_good = 1'b0;
    logic [1:0] strap_lvl = 2'b01;
    logic       scl_drv = 1'b1;
    logic       sda_host_low = 1'b0;
    logic       sda_line;
    logic       sda_drive_low;
    logic [4:0] out_en;
    logic [1:0] amp_sel;
    logic [4:0] slew_fast;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic [7:0] obs_q[$];

    always #4 clk = ~clk;

    assign sda_line = ~(sda_host_low | sda_drive_low);

    smbr_target dut (
        .clk(clk), .rst_n(rst_n), .refclk_ok(refclk_ok), .pwr_good(pwr_good),
        .strap_lvl(strap_lvl), .scl_in(scl_drv), .sda_in(sda_line),
        .sda_drive_low(sda_drive_low), .out_en(out_en), .amp_sel(amp_sel),
        .slew_fast(slew_fast)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_byte(input logic [7:0] v, input string t);
        exp_q.push_back(v);
        tag_q.push_back(t);
    endtask

    task automatic bus_start;
        sda_host_low = 1'b0; tick(Q);
        scl_drv = 1'b1;      tick(Q);
        sda_host_low = 1'b1; tick(Q);
        scl_drv = 1'b0;      tick(Q);
    endtask

    task automatic bus_stop;
        sda_host_low = 1'b1; tick(Q);
        scl_drv = 1'b1;      tick(Q);
        sda_host_low = 1'b0; tick(Q);
    endtask

    task automatic send_bit(input logic b);
        sda_host_low = ~b; tick(Q);
        scl_drv = 1'b1;    tick(2*Q);
        scl_drv = 1'b0;    tick(Q);
    endtask

    task automatic recv_bit(output logic b);
        sda_host_low = 1'b0; tick(Q);
        scl_drv = 1'b1;      tick(Q);
        b = sda_line;        tick(Q);
        scl_drv = 1'b0;      tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] d, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
        recv_bit(b);
        ack = ~b;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] d);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(b);
            d[i] = b;
        end
        send_bit(~give_ack);
        sda_host_low = 1'b0;
    endtask

    task automatic probe(input logic [6:0] a, input logic exp_ack, input string tag);
        logic ack;
        bus_start;
        send_byte({a, 1'b0}, ack);
        check(ack == exp_ack, tag, ack, exp_ack);
        bus_stop;
    endtask

    // Full indexed block write with every byte expected to be acknowledged.
    task automatic wr_block(input logic [7:0] idx, input logic [7:0] d0, input logic [7:0] d1,
                            input int n, input string tag);
        logic ack;
        bus_start;
        send_byte({7'h6C, 1'b0}, ack); check(ack, tag, ack, 1);
        send_byte(idx, ack);           check(ack, tag, ack, 1);
        send_byte(8'(n), ack);         check(ack, tag, ack, 1);
        send_byte(d0, ack);            check(ack, tag, ack, 1);
        if (n > 1) begin
            send_byte(d1, ack);        check(ack, tag, ack, 1);
        end
        bus_stop;
    endtask

    // Indexed read of n bytes; observed bytes go to the scoreboard.
    task automatic rd_block(input logic [7:0] idx, input int n, input string tag);
        logic ack;
        logic [7:0] d;
        bus_start;
        send_byte({7'h6C, 1'b0}, ack); check(ack, tag, ack, 1);
        send_byte(idx, ack);           check(ack, tag, ack, 1);
        bus_start;
        send_byte({7'h6C, 1'b1}, ack); check(ack, tag, ack, 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(i < n - 1, d);
            obs_q.push_back(d);
        end
        bus_stop;
    endtask

    task automatic do_reset(input logic [1:0] s);
        pwr_good = 1'b0;
        rst_n = 1'b0;
        strap_lvl = s;
        tick(5);
        rst_n = 1'b1;
        tick(5);
    endtask

    // Scoreboard monitor: pops observed bytes and compares with expectations.
    initial begin
        forever begin
            @(negedge clk);
            while (obs_q.size() > 0) begin
                logic [7:0] o;
                logic [7:0] e;
                string t;
                o = obs_q.pop_front();
                if (exp_q.size() == 0) begin
                    check(1'b0, "R6 scoreboard underflow", o, 0);
                end else begin
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(o == e, t, o, e);
                end
            end
        end
    end

    // Watchdog
    initial begin
        tick(190000);
        check(1'b0, "watchdog expired", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic ack;
        logic [7:0] d;
        do_reset(2'b01);

        // R1 reset state
        check(out_en == 5'h1F, "R1 out_en", out_en, 5'h1F);
        check(amp_sel == 2'b10, "R1 amp_sel", amp_sel, 2'b10);
        check(slew_fast == 5'h1F, "R1 slew_fast", slew_fast, 5'h1F);
        check(sda_drive_low == 1'b0, "R1 sda", sda_drive_low, 0);

        // R2 address strap latch
        probe(7'h6C, 1'b0, "R2 before power-good");
        pwr_good = 1'b1; tick(4);
        probe(7'h6B, 1'b0, "R2 other address");
        probe(7'h6C, 1'b1, "R2 mid strap address");
        strap_lvl = 2'b10; pwr_good = 1'b0; tick(4); pwr_good = 1'b1; tick(4);
        probe(7'h6C, 1'b1, "R2 strap relatch ignored");
        probe(7'h6D, 1'b0, "R2 strap relatch ignored high");

        // R3 mismatched address: later bytes are not acknowledged either
        bus_start;
        send_byte({7'h50, 1'b0}, ack); check(!ack, "R3 mismatch nack", ack, 0);
        send_byte(8'h00, ack);          check(!ack, "R3 silent after mismatch", ack, 0);
        check(sda_drive_low == 1'b0, "R3 released", sda_drive_low, 0);
        bus_stop;

        // R6 R7 default read: count then eight bytes
        expect_byte(8'h08, "R6 count byte");
        expect_byte(8'h0F, "R6 byte0");
        expect_byte(8'h06, "R6 byte1");
        expect_byte(8'h0F, "R6 byte2");
        expect_byte(8'h01, "R6 byte3");
        expect_byte(8'hFF, "R7 byte4");
        expect_byte(8'h01, "R7 byte5");
        expect_byte(8'hC5, "R7 byte6");
        expect_byte(8'h08, "R6 byte7");
        rd_block(8'd0, 9, "R6 read setup");

        // R4 R5 R10 write with an extra byte past the count
        bus_start;
        send_byte({7'h6C, 1'b0}, ack); check(ack, "R4 addr", ack, 1);
        send_byte(8'd0, ack);          check(ack, "R4 index", ack, 1);
        send_byte(8'd2, ack);          check(ack, "R4 count", ack, 1);
        send_byte(8'hF5, ack);         check(ack, "R4 data0", ack, 1);
        send_byte(8'hFD, ack);         check(ack, "R4 data1", ack, 1);
        send_byte(8'h00, ack);         check(!ack, "R4 past count nack", ack, 0);
        bus_stop;
        tick(4);
        check(out_en == 5'h15, "R10 R5 out_en", out_en, 5'h15);
        check(amp_sel == 2'b01, "R10 amp_sel", amp_sel, 2'b01);

        wr_block(8'd2, 8'h0A, 8'hFE, 2, "R4 slew write");
        tick(4);
        check(slew_fast == 5'h0A, "R10 slew_fast", slew_fast, 5'h0A);

        // R5 read-only bytes and out-of-range index
        bus_start;
        send_byte({7'h6C, 1'b0}, ack); check(ack, "R5 addr", ack, 1);
        send_byte(8'd4, ack);          check(ack, "R5 index", ack, 1);
        send_byte(8'd3, ack);          check(ack, "R5 count", ack, 1);
        for (int i = 0; i < 3; i++) begin
            send_byte(8'h00, ack);     check(ack, "R5 ro byte ack", ack, 1);
        end
        bus_stop;
        wr_block(8'd10, 8'h00, 8'h00, 1, "R5 out-of-range write acked");

        // Readback count lowered to 3 (upper bits reserved)
        wr_block(8'd7, 8'hE3, 8'h00, 1, "R5 count write");

        expect_byte(8'h03, "R6 count lowered");
        expect_byte(8'h05, "R5 byte0 masked");
        expect_byte(8'h05, "R5 byte1 masked");
        expect_byte(8'h0A, "R4 byte2");
        expect_byte(8'hFF, "R8 past count");
        rd_block(8'd0, 5, "R8 read setup");

        expect_byte(8'h03, "R6 count");
        expect_byte(8'hFF, "R5 byte4 unwritable");
        expect_byte(8'h01, "R5 byte5 unwritable");
        expect_byte(8'hC5, "R5 byte6 unwritable");
        rd_block(8'd4, 4, "R7 read setup");

        expect_byte(8'h03, "R6 count");
        expect_byte(8'hFF, "R7 index 9");
        expect_byte(8'hFF, "R7 index 10");
        expect_byte(8'hFF, "R7 index 11");
        rd_block(8'd9, 4, "R7 range setup");

        // R9 NACK after the count byte ends the read
        bus_start;
        send_byte({7'h6C, 1'b1}, ack); check(ack, "R9 addr", ack, 1);
        recv_byte(1'b0, d);
        check(d == 8'h03, "R9 count before nack", d, 8'h03);
        check(sda_drive_low == 1'b0, "R9 released after nack", sda_drive_low, 0);
        bus_stop;
        probe(7'h6C, 1'b1, "R9 next transfer served");

        // R11 stop in the middle of a data byte
        bus_start;
        send_byte({7'h6C, 1'b0}, ack);
        send_byte(8'd0, ack);
        send_byte(8'd1, ack);
        for (int i = 0; i < 4; i++) send_bit(1'b0);
        bus_stop;
        // R11 start in the middle of a data byte, then read back
        bus_start;
        send_byte({7'h6C, 1'b0}, ack);
        send_byte(8'd2, ack);
        send_byte(8'd1, ack);
        for (int i = 0; i < 3; i++) send_bit(1'b0);
        expect_byte(8'h03, "R11 count");
        expect_byte(8'h0A, "R11 byte2 kept after start abort");
        rd_block(8'd2, 2, "R11 read");
        expect_byte(8'h03, "R11 count");
        expect_byte(8'h05, "R11 byte0 kept after stop abort");
        rd_block(8'd0, 2, "R11 read");

        // R12 engine gated off without reference clock
        refclk_ok = 1'b0;
        probe(7'h6C, 1'b0, "R12 ignored without refclk");
        refclk_ok = 1'b1;
        probe(7'h6C, 1'b1, "R12 served again");

        // R2 other strap levels after reset; R1 fields restored
        do_reset(2'b00);
        check(out_en == 5'h1F, "R1 out_en after reset", out_en, 5'h1F);
        pwr_good = 1'b1; tick(4);
        probe(7'h6B, 1'b1, "R2 low strap");
        probe(7'h6C, 1'b0, "R2 low strap other");
        do_reset(2'b10);
        pwr_good = 1'b1; tick(4);
        probe(7'h6D, 1'b1, "R2 high strap");

        tick(20);
        check(exp_q.size() == 0, "R6 scoreboard drained", exp_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule